// File: doc/BRIEF.md
# Prompt In-Phase Integrate-and-Dump Channel with Mixer Bypass

This block is the prompt in-phase arm of one correlator channel. Each enabled cycle it takes a two-bit front-end sample (a sign bit and a magnitude bit) and turns it into a signed level. It multiplies that level by a carrier level, chosen by a two-bit carrier phase, and by the current code chip. It adds the product to a running integrator. A dump strobe, supplied by the code generator once per integration period, copies the integrator into a registered result and restarts the integration.

A small configuration register, written through `cfg_we`, holds four test controls. One replaces the carrier level with +1. One makes the code mixer transparent. One forces a front-end input bit low, and one selects which bit is forced. With both mixers bypassed and the magnitude bit forced low, each sample adds +1 when the sign bit is high and -1 when it is low. The dumped value then equals the high count minus the low count, so the duty cycle over N samples is (N + ACC) / 2N. Selecting the magnitude measurement forces the sign bit low instead, so the magnitude bit's duty cycle can be read the same way.

Top module: `pi_intdump`

## Requirements
- R1: A synchronous reset drives `acc_out` to 0 and `dump_valid` to 0, and clears all four configuration bits, so that the carrier and code mixers are active after reset.
- R2: The sample level is +1 for sign=1 and mag=0, +3 for sign=1 and mag=1, -1 for sign=0 and mag=0, and -3 for sign=0 and mag=1.
- R3: The carrier level is +1 for `car_phase`=00, +2 for 01, -1 for 10 and -2 for 11. While `phase_clr` is high, the phase is taken as 00, which gives +1.
- R4: While the stored carrier-bypass bit is set, the carrier level is +1 whatever the phase.
- R5: The code factor is +1 for `code_chip`=1 and -1 for `code_chip`=0. While the stored code-off bit is set, the factor is +1.
- R6: A dump sampled on a clock edge loads `acc_out` on that same edge with the sum of all products enabled since the previous dump. `dump_valid` is high for exactly the cycle that follows. The sample enabled in the dump cycle becomes the first term of the next period.
- R7: A cycle with `sample_en` low adds nothing to the integrator.
- R8: With the front-end test bit set, the magnitude input is forced low when the measure-magnitude bit is 0, and the sign input is forced low when that bit is 1.
- R9: With both mixers bypassed and the magnitude input forced low, a period of N samples with K sign-high samples dumps K - (N - K). This makes N + ACC equal to 2K, so (N + ACC) / 2N is the sign duty cycle.
- R10: `acc_out` holds its value between dumps.
- R11: Configuration bits written with `cfg_we` take effect from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads the four configuration bits |
| cfg_car_bypass | input | 1 | Carrier level forced to +1 |
| cfg_code_off | input | 1 | Code mixer made transparent |
| cfg_fe_test | input | 1 | Enables forcing of one front-end bit low |
| cfg_meas_mag | input | 1 | 0: force magnitude low; 1: force sign low |
| sample_en | input | 1 | Current sample is valid |
| sgn_in | input | 1 | Front-end sign bit |
| mag_in | input | 1 | Front-end magnitude bit |
| car_phase | input | 2 | Carrier phase selecting the carrier level |
| phase_clr | input | 1 | Channel reset holding the carrier phase at zero |
| code_chip | input | 1 | Current code chip (1 = +1, 0 = -1) |
| dump | input | 1 | End of integration period |
| acc_out | output | ACC_W | Signed dumped integration result |
| dump_valid | output | 1 | One-cycle pulse after a dump |

## Verification
The assertions assume that `dump` arrives often enough for the integrator to stay within range. A period must hold no more than `MAX_SAMPLES` enabled samples. They also assume that reset is asserted from time zero until the first edges. The stimulus keeps every period to a few dozen samples. It ends each period with an explicit dump, and it changes configuration only in cycles where `sample_en` and `dump` are low. This keeps each period's expected sum a closed-form count of high and low samples.

// File: rtl/pi_intdump_pkg.sv
package pi_intdump_pkg;
  localparam int LVL_W  = 3;  // signed sample / carrier level
  localparam int PROD_W = 4;  // signed |product| <= 6

  typedef struct packed {
    logic car_bypass;
    logic code_off;
    logic fe_test;
    logic meas_mag;
  } pi_cfg_t;

  function automatic int acc_width(input int max_samples);
    return $clog2(6 * max_samples + 1) + 1;
  endfunction
endpackage

// File: rtl/pi_cfg_reg.sv
module pi_cfg_reg
  import pi_intdump_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  pi_cfg_t cfg_d,
  output pi_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/pi_frontend.sv
module pi_frontend
  import pi_intdump_pkg::*;
(
  input  logic                    sgn,
  input  logic                    mag,
  input  logic                    fe_test,
  input  logic                    meas_mag,
  output logic signed [LVL_W-1:0] lvl
);
  logic s_eff, m_eff;

  always_comb begin
    s_eff = sgn;
    m_eff = mag;
    if (fe_test) begin
      if (meas_mag) s_eff = 1'b0;
      else          m_eff = 1'b0;
    end
    case ({s_eff, m_eff})
      2'b10:   lvl = 3'sd1;
      2'b11:   lvl = 3'sd3;
      2'b00:   lvl = -3'sd1;
      default: lvl = -3'sd3;
    endcase
  end
endmodule

// File: rtl/pi_mixer.sv
module pi_mixer
  import pi_intdump_pkg::*;
(
  input  logic signed [LVL_W-1:0]  lvl,
  input  logic [1:0]               phase,
  input  logic                     phase_clr,
  input  logic                     chip,
  input  logic                     car_bypass,
  input  logic                     code_off,
  output logic signed [LVL_W-1:0]  car_lvl,
  output logic signed [PROD_W-1:0] prod
);
  logic [1:0]               ph_eff;
  logic signed [PROD_W-1:0] a_ext, b_ext, p_car;
  logic                     code_neg;

  always_comb begin
    ph_eff = phase_clr ? 2'b00 : phase;
    if (car_bypass) car_lvl = 3'sd1;
    else begin
      case (ph_eff)
        2'b00:   car_lvl = 3'sd1;
        2'b01:   car_lvl = 3'sd2;
        2'b10:   car_lvl = -3'sd1;
        default: car_lvl = -3'sd2;
      endcase
    end
    a_ext    = {lvl[LVL_W-1], lvl};
    b_ext    = {car_lvl[LVL_W-1], car_lvl};
    p_car    = a_ext * b_ext;
    code_neg = !code_off && !chip;
    prod     = code_neg ? -p_car : p_car;
  end
endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
  import pi_intdump_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     dump,
  input  logic signed [PROD_W-1:0] prod,
  output logic signed [ACC_W-1:0]  integ,
  output logic signed [ACC_W-1:0]  acc_q,
  output logic                     vld_q
);
  logic signed [ACC_W-1:0] prod_ext;

  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      integ <= '0;
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= dump;
      if (dump) begin
        acc_q <= integ;
        integ <= en ? prod_ext : '0;
      end else if (en) begin
        integ <= integ + prod_ext;
      end
    end
  end
endmodule

// File: rtl/pi_intdump.sv
module pi_intdump
  import pi_intdump_pkg::*;
#(
  parameter  int MAX_SAMPLES = 65536,
  localparam int ACC_W       = acc_width(MAX_SAMPLES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic                    cfg_car_bypass,
  input  logic                    cfg_code_off,
  input  logic                    cfg_fe_test,
  input  logic                    cfg_meas_mag,
  input  logic                    sample_en,
  input  logic                    sgn_in,
  input  logic                    mag_in,
  input  logic [1:0]              car_phase,
  input  logic                    phase_clr,
  input  logic                    code_chip,
  input  logic                    dump,
  output logic signed [ACC_W-1:0] acc_out,
  output logic                    dump_valid
);
  pi_cfg_t                  cfg_d, cfg_q;
  logic signed [LVL_W-1:0]  fe_lvl, car_lvl;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  integ;

  assign cfg_d = '{car_bypass: cfg_car_bypass, code_off: cfg_code_off,
                   fe_test: cfg_fe_test, meas_mag: cfg_meas_mag};

  pi_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .cfg_d(cfg_d), .cfg_q(cfg_q)
  );

  pi_frontend u_fe (
    .sgn(sgn_in), .mag(mag_in), .fe_test(cfg_q.fe_test),
    .meas_mag(cfg_q.meas_mag), .lvl(fe_lvl)
  );

  pi_mixer u_mix (
    .lvl(fe_lvl), .phase(car_phase), .phase_clr(phase_clr), .chip(code_chip),
    .car_bypass(cfg_q.car_bypass), .code_off(cfg_q.code_off),
    .car_lvl(car_lvl), .prod(prod)
  );

  pi_integrator #(.ACC_W(ACC_W)) u_int (
    .clk(clk), .rst(rst), .en(sample_en), .dump(dump), .prod(prod),
    .integ(integ), .acc_q(acc_out), .vld_q(dump_valid)
  );
endmodule

// File: rtl/pi_intdump_chk.sv
module pi_intdump_chk #(
  parameter int ACC_W = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sample_en,
  input logic                    dump,
  input logic                    dump_valid,
  input logic signed [ACC_W-1:0] acc_out,
  input logic signed [ACC_W-1:0] integ,
  input logic signed [2:0]       fe_lvl,
  input logic signed [2:0]       car_lvl,
  input logic                    car_bypass,
  input logic                    fe_test,
  input logic                    meas_mag
);
  p_valid_after_dump_r6: assert property (@(posedge clk) disable iff (rst)
    dump |=> dump_valid);
  p_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
    !dump |=> !dump_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !dump_valid |-> $stable(acc_out));
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!sample_en && !dump) |=> $stable(integ));
  p_level_set_r2: assert property (@(posedge clk) disable iff (rst)
    (fe_lvl == 3'sd1) || (fe_lvl == 3'sd3) || (fe_lvl == -3'sd1) || (fe_lvl == -3'sd3));
  p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    car_bypass |-> (car_lvl == 3'sd1));
  p_mag_forced_r8: assert property (@(posedge clk) disable iff (rst)
    (fe_test && !meas_mag) |-> ((fe_lvl == 3'sd1) || (fe_lvl == -3'sd1)));
  p_sign_forced_r8: assert property (@(posedge clk) disable iff (rst)
    (fe_test && meas_mag) |-> (fe_lvl < 0));
endmodule

bind pi_intdump pi_intdump_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .sample_en(sample_en), .dump(dump),
  .dump_valid(dump_valid), .acc_out(acc_out), .integ(integ),
  .fe_lvl(fe_lvl), .car_lvl(car_lvl), .car_bypass(cfg_q.car_bypass),
  .fe_test(cfg_q.fe_test), .meas_mag(cfg_q.meas_mag)
);

// File: tb/test_pi_intdump.sv
module test_pi_intdump;
  import pi_intdump_pkg::*;
  localparam int AW = acc_width(65536);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_car_bypass = 0, cfg_code_off = 0, cfg_fe_test = 0, cfg_meas_mag = 0;
  logic sample_en = 0, sgn_in = 0, mag_in = 0, phase_clr = 0, code_chip = 0, dump = 0;
  logic [1:0] car_phase = 2'b00;
  logic signed [AW-1:0] acc_out;
  logic dump_valid;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  pi_intdump i_pi_intdump (.*);

  typedef struct packed {
    logic byp; logic coff; logic fe; logic mms;
    logic [1:0] ph; logic chip; logic mag;
    logic [7:0] n; logic [7:0] k;
    logic signed [15:0] exp_acc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 8'd20, 8'd10, 16'sd0},    // R9 50%
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 8'd20, 8'd15, 16'sd10},   // R9 75%
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 8'd16, 8'd4,  -16'sd8},   // R9 25%
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'd10, 8'd10, 16'sd20},   // R3 +2
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 8'd8,  8'd8,  16'sd48},   // R2 R3 R5
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 8'd6,  8'd0,  16'sd18},   // R2 R3 R5
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 8'd10, 8'd10, -16'sd30},  // R8 sign forced
    '{1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd12, 8'd3,  16'sd6}     // R4 R5
  };

  task automatic check(input string what, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic do_cfg(input logic b, input logic c, input logic f, input logic m);
    @(negedge clk);
    cfg_we = 1; cfg_car_bypass = b; cfg_code_off = c; cfg_fe_test = f; cfg_meas_mag = m;
    sample_en = 0; dump = 0;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(input int n, input int k, input logic [1:0] ph,
                     input logic chip, input logic mag, input logic en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_en = en; sgn_in = (i < k); mag_in = mag; car_phase = ph; code_chip = chip;
    end
  endtask

  // dump with optional sample in the dump cycle; returns the dumped value
  task automatic do_dump(input logic en, input logic sg, input string tag, output int val);
    @(negedge clk);
    dump = 1; sample_en = en; sgn_in = sg;
    @(negedge clk);
    dump = 0; sample_en = 0;
    val = int'(acc_out);
    check({tag, " dump_valid after dump"}, int'(dump_valid), 1);
  endtask

  int v, held;

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 acc_out after reset", int'(acc_out), 0);
    check("R1 dump_valid after reset", int'(dump_valid), 0);

    // R1: configuration cleared by reset -> mixers active again
    do_cfg(1, 1, 1, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    run(4, 4, 2'd1, 1'b1, 1'b0, 1'b1);
    do_dump(0, 0, "R1", v);
    check("R1 mixers active after reset (4*1*2*1)", v, 8);
    @(negedge clk);
    check("R6 dump_valid single pulse", int'(dump_valid), 0);

    // vector table
    for (int r = 0; r < 8; r++) begin
      do_cfg(VECS[r].byp, VECS[r].coff, VECS[r].fe, VECS[r].mms);
      run(int'(VECS[r].n), int'(VECS[r].k), VECS[r].ph, VECS[r].chip, VECS[r].mag, 1'b1);
      do_dump(0, 0, "R6", v);
      check($sformatf("R2 R3 R4 R5 R8 R9 vector %0d dumped sum", r), v, int'(VECS[r].exp_acc));
      if (r < 3)
        check($sformatf("R9 duty N+ACC==2K vector %0d", r), int'(VECS[r].n) + v, 2 * int'(VECS[r].k));
    end

    // R3: phase_clr forces +1 even with phase 11
    do_cfg(0, 1, 1, 0);
    phase_clr = 1;
    run(5, 5, 2'd3, 1'b0, 1'b0, 1'b1);
    do_dump(0, 0, "R3", v);
    phase_clr = 0;
    check("R3 phase_clr gives +1 level", v, 5);

    // R7: disabled samples ignored
    do_cfg(1, 1, 0, 0);
    run(6, 6, 2'd1, 1'b0, 1'b1, 1'b0);
    do_dump(0, 0, "R7", v);
    check("R7 disabled samples add nothing", v, 0);

    // R6: sample in dump cycle starts the next period; R10 hold
    do_cfg(1, 1, 1, 0);
    run(3, 3, 2'd0, 1'b0, 1'b0, 1'b1);
    do_dump(1, 1, "R6", v);
    check("R6 dump excludes dump-cycle sample", v, 3);
    held = int'(acc_out);
    run(5, 0, 2'd0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); sample_en = 0;
    check("R10 acc_out held between dumps", int'(acc_out), held);
    do_dump(0, 0, "R6", v);
    check("R6 dump-cycle sample carried (+1 then 5*-1)", v, -4);

    // R11: configuration takes effect only after write
    do_cfg(0, 0, 0, 0);
    @(negedge clk);
    cfg_we = 1; cfg_car_bypass = 1; cfg_code_off = 1; sample_en = 0;
    @(negedge clk);
    cfg_we = 0; cfg_car_bypass = 0; cfg_code_off = 0;
    run(4, 4, 2'd3, 1'b0, 1'b0, 1'b1);
    do_dump(0, 0, "R11", v);
    check("R11 stored bypass used, port value ignored after write", v, 4);

    // back-to-back dumps with nothing in between
    do_dump(0, 0, "R6", v);
    check("R6 empty period dumps zero", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule